// File: doc/BRIEF.md
# Interlaced Sync Timing Counter Core

This block is the counting heart of an interlaced video sync generator. A horizontal counter walks through the pixel clocks of each line. A vertical counter advances twice per line, once at the half-line point and once at the line end, so it counts in half-line units. Because of this, a frame with an odd number of lines splits into an odd field and an even field that are offset by half a line.

Six set/reset window flops compare the live counters for equality against programmed 12-bit edge values. From these flops the block forms four active-low outputs:

- composite sync
- composite blank
- line drive
- frame drive

It also drives a flag that is high during the odd field. The edge values arrive as plain parallel inputs.

The block is stopped at power-up. Generation starts only after the enable bit is written to 1. Three controls act on it:

- Freeze halts everything in place.
- Restart parks the counters at the first clock of the first odd line while keeping the enable bit. Releasing it gen-locks the sequence to an external moment.
- Clear parks the counters in the same way and also drops the enable bit.

Top module: `stc_timing_core`

## Requirements
- R1: After reset the horizontal count is 1, the vertical count is 1 (start of the odd field), every active-low output is high, odd_field is 1, and the enable bit is 0, so nothing advances.
- R2: A cycle with en_load high writes en_bit into the enable bit. Counting starts on the first clock after the write of 1, and a write of 0 stops all advance.
- R3: While running, the horizontal count steps by 1 per clock from 1 up to h_total and then returns to 1.
- R4: The vertical count steps by one half-line on each running clock where the horizontal count equals h_total or h_total>>1. It wraps from v_total to 1. odd_field is 1 exactly while the vertical count is at most v_total>>1.
- R5: Horizontal sync, blank and drive windows each become active on the running clock after the horizontal count equals their "on" value, and inactive on the running clock after it equals their "off" value (with 2 <= on < off <= h_total). line_drive_n is low while the horizontal drive window is active.
- R6: Vertical sync, blank and drive windows behave the same way against the vertical count (with 2 <= on < off <= v_total). frame_drive_n is low while the vertical drive window is active.
- R7: comp_sync_n is low when exactly one of the horizontal and vertical sync windows is active, which serrates sync during vertical sync. comp_blank_n is low when either blank window is active.
- R8: While freeze is high and neither restart nor clear is high, the counters and all window states hold. After release, counting resumes with no skipped or repeated count.
- R9: While restart is high, both counters are held at 1 and all windows are inactive, and the enable bit is kept. The first running clock after release processes horizontal count 1 of the first odd line.
- R10: Clear does everything restart does and also sets the enable bit to 0. The block then stays stopped until the bit is written to 1 again.
- R11: Priority: clear beats an en_load in the same cycle, and restart or clear beats freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_load | input | 1 | Write strobe for the enable bit |
| en_bit | input | 1 | Value written to the enable bit |
| freeze | input | 1 | Hold all counters and windows |
| restart | input | 1 | Park at start of first odd line, keep enable |
| clear | input | 1 | Park and drop enable |
| h_total | input | 12 | Pixels per line |
| h_sync_on | input | 12 | Horizontal sync start count |
| h_sync_off | input | 12 | Horizontal sync end count |
| h_blank_on | input | 12 | Horizontal blank start count |
| h_blank_off | input | 12 | Horizontal blank end count |
| h_drive_on | input | 12 | Line drive start count |
| h_drive_off | input | 12 | Line drive end count |
| v_total | input | 12 | Half-lines per frame |
| v_sync_on | input | 12 | Vertical sync start (half-lines) |
| v_sync_off | input | 12 | Vertical sync end (half-lines) |
| v_blank_on | input | 12 | Vertical blank start (half-lines) |
| v_blank_off | input | 12 | Vertical blank end (half-lines) |
| v_drive_on | input | 12 | Frame drive start (half-lines) |
| v_drive_off | input | 12 | Frame drive end (half-lines) |
| comp_sync_n | output | 1 | Composite sync, active low |
| comp_blank_n | output | 1 | Composite blank, active low |
| line_drive_n | output | 1 | Line drive, active low |
| frame_drive_n | output | 1 | Frame drive, active low |
| odd_field | output | 1 | High during the odd field |

## Verification
Two pairs of controls can collide in a single cycle: a restart with a freeze, and a clear with a write to the enable bit. Directed steps raise each pair together at chosen points mid-line. A random phase then draws all four controls independently every cycle, so the pairs also overlap at arbitrary counter positions. The bench model settles every collision by the priority in R11: the counters are parked and a pending enable write is lost to clear. Every later output is then compared against that resolution.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [1:0] {
    CTL_HOLD = 2'd0,
    CTL_RUN  = 2'd1,
    CTL_HOME = 2'd2
  } ctl_e;

  localparam int NUM_HWIN   = 3;
  localparam int NUM_WIN    = 6;
  localparam int WIN_HSYNC  = 0;
  localparam int WIN_HBLANK = 1;
  localparam int WIN_HDRIVE = 2;
  localparam int WIN_VSYNC  = 3;
  localparam int WIN_VBLANK = 4;
  localparam int WIN_VDRIVE = 5;
endpackage

// File: rtl/stc_ctrl.sv
module stc_ctrl
  import stc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_load,
  input  logic en_bit,
  input  logic freeze,
  input  logic restart,
  input  logic clear,
  output ctl_e ctl,
  output logic run_en
);
  // enable bit: clear dominates a same-cycle write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_en <= 1'b0;
    else if (clear)   run_en <= 1'b0;
    else if (en_load) run_en <= en_bit;
  end

  // home beats freeze; run needs the enable bit
  always_comb begin
    if (clear || restart)      ctl = CTL_HOME;
    else if (run_en && !freeze) ctl = CTL_RUN;
    else                        ctl = CTL_HOLD;
  end
endmodule

// File: rtl/stc_hcount.sv
module stc_hcount
  import stc_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_e          ctl,
  input  logic [CW-1:0] h_total,
  output logic [CW-1:0] hcnt,
  output logic          line_end,
  output logic          half_point,
  output logic          v_step
);
  localparam logic [CW-1:0] FIRST = CW'(1);

  function automatic logic [CW-1:0] next_pos(input logic [CW-1:0] cur, input logic [CW-1:0] last);
    return (cur == last) ? FIRST : cur + FIRST;
  endfunction

  function automatic logic [CW-1:0] mid_of(input logic [CW-1:0] total);
    return total >> 1;
  endfunction

  assign line_end   = (hcnt == h_total);
  assign half_point = (hcnt == mid_of(h_total));
  assign v_step     = line_end || half_point;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hcnt <= FIRST;
    else if (ctl == CTL_HOME) hcnt <= FIRST;
    else if (ctl == CTL_RUN)  hcnt <= next_pos(hcnt, h_total);
  end
endmodule

// File: rtl/stc_vcount.sv
module stc_vcount
  import stc_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_e          ctl,
  input  logic          v_step,
  input  logic [CW-1:0] v_total,
  output logic [CW-1:0] vcnt,
  output logic          odd_field
);
  localparam logic [CW-1:0] FIRST = CW'(1);

  function automatic logic [CW-1:0] next_half(input logic [CW-1:0] cur, input logic [CW-1:0] last);
    return (cur == last) ? FIRST : cur + FIRST;
  endfunction

  function automatic logic in_first_field(input logic [CW-1:0] cur, input logic [CW-1:0] total);
    return cur <= (total >> 1);
  endfunction

  assign odd_field = in_first_field(vcnt, v_total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        vcnt <= FIRST;
    else if (ctl == CTL_HOME)          vcnt <= FIRST;
    else if (ctl == CTL_RUN && v_step) vcnt <= next_half(vcnt, v_total);
  end
endmodule

// File: rtl/stc_edge_flop.sv
module stc_edge_flop
  import stc_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_e          ctl,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] on_at,
  input  logic [CW-1:0] off_at,
  output logic          active
);
  logic hit_on, hit_off;
  assign hit_on  = (cnt == on_at);
  assign hit_off = (cnt == off_at);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               active <= 1'b0;
    else if (ctl == CTL_HOME) active <= 1'b0;
    else if (ctl == CTL_RUN) begin
      if (hit_off)     active <= 1'b0;
      else if (hit_on) active <= 1'b1;
    end
  end
endmodule

// File: rtl/stc_timing_core.sv
module stc_timing_core
  import stc_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_load,
  input  logic          en_bit,
  input  logic          freeze,
  input  logic          restart,
  input  logic          clear,
  input  logic [CW-1:0] h_total,
  input  logic [CW-1:0] h_sync_on,
  input  logic [CW-1:0] h_sync_off,
  input  logic [CW-1:0] h_blank_on,
  input  logic [CW-1:0] h_blank_off,
  input  logic [CW-1:0] h_drive_on,
  input  logic [CW-1:0] h_drive_off,
  input  logic [CW-1:0] v_total,
  input  logic [CW-1:0] v_sync_on,
  input  logic [CW-1:0] v_sync_off,
  input  logic [CW-1:0] v_blank_on,
  input  logic [CW-1:0] v_blank_off,
  input  logic [CW-1:0] v_drive_on,
  input  logic [CW-1:0] v_drive_off,
  output logic          comp_sync_n,
  output logic          comp_blank_n,
  output logic          line_drive_n,
  output logic          frame_drive_n,
  output logic          odd_field
);
  ctl_e          ctl;
  logic          run_en;
  logic [CW-1:0] hcnt, vcnt;
  logic          line_end, half_point, v_step;
  logic [NUM_WIN-1:0] win_act;
  logic [CW-1:0] on_v  [NUM_WIN];
  logic [CW-1:0] off_v [NUM_WIN];

  assign on_v[WIN_HSYNC]   = h_sync_on;
  assign off_v[WIN_HSYNC]  = h_sync_off;
  assign on_v[WIN_HBLANK]  = h_blank_on;
  assign off_v[WIN_HBLANK] = h_blank_off;
  assign on_v[WIN_HDRIVE]  = h_drive_on;
  assign off_v[WIN_HDRIVE] = h_drive_off;
  assign on_v[WIN_VSYNC]   = v_sync_on;
  assign off_v[WIN_VSYNC]  = v_sync_off;
  assign on_v[WIN_VBLANK]  = v_blank_on;
  assign off_v[WIN_VBLANK] = v_blank_off;
  assign on_v[WIN_VDRIVE]  = v_drive_on;
  assign off_v[WIN_VDRIVE] = v_drive_off;

  stc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_load(en_load), .en_bit(en_bit),
    .freeze(freeze), .restart(restart), .clear(clear),
    .ctl(ctl), .run_en(run_en)
  );

  stc_hcount #(.CW(CW)) u_hcount (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .h_total(h_total),
    .hcnt(hcnt), .line_end(line_end), .half_point(half_point), .v_step(v_step)
  );

  stc_vcount #(.CW(CW)) u_vcount (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .v_step(v_step), .v_total(v_total),
    .vcnt(vcnt), .odd_field(odd_field)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    if (i < NUM_HWIN) begin : g_h
      stc_edge_flop #(.CW(CW)) u_win (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .cnt(hcnt),
        .on_at(on_v[i]), .off_at(off_v[i]), .active(win_act[i])
      );
    end else begin : g_v
      stc_edge_flop #(.CW(CW)) u_win (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .cnt(vcnt),
        .on_at(on_v[i]), .off_at(off_v[i]), .active(win_act[i])
      );
    end
  end

  assign comp_sync_n   = ~(win_act[WIN_HSYNC] ^ win_act[WIN_VSYNC]);
  assign comp_blank_n  = ~(win_act[WIN_HBLANK] | win_act[WIN_VBLANK]);
  assign line_drive_n  = ~win_act[WIN_HDRIVE];
  assign frame_drive_n = ~win_act[WIN_VDRIVE];
endmodule

// File: rtl/stc_timing_chk.sv
module stc_timing_chk
  import stc_pkg::*;
#(
  parameter int CW = 12
) (
  input logic               clk,
  input logic               rst_n,
  input ctl_e               ctl,
  input logic               clear,
  input logic               run_en,
  input logic [CW-1:0]      hcnt,
  input logic [CW-1:0]      vcnt,
  input logic               line_end,
  input logic               v_step,
  input logic [NUM_WIN-1:0] win_act
);
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == CTL_RUN && line_end) |=> (hcnt == CW'(1)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == CTL_RUN && !line_end) |=> (hcnt == $past(hcnt) + CW'(1)));

  assert_vhold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == CTL_RUN && !v_step) |=> $stable(vcnt));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == CTL_HOLD) |=> ($stable(hcnt) && $stable(vcnt) && $stable(win_act)));

  assert_home_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == CTL_HOME) |=> (hcnt == CW'(1) && vcnt == CW'(1) && win_act == '0));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !run_en);
endmodule

bind stc_timing_core stc_timing_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl(ctl), .clear(clear), .run_en(run_en),
  .hcnt(hcnt), .vcnt(vcnt), .line_end(line_end), .v_step(v_step), .win_act(win_act)
);

// File: tb/tb_stc_timing_core.sv
module tb_stc_timing_core;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_load = 1'b0, en_bit = 1'b0, freeze = 1'b0, restart = 1'b0, clear = 1'b0;
  logic [CW-1:0] h_total, h_sync_on, h_sync_off, h_blank_on, h_blank_off, h_drive_on, h_drive_off;
  logic [CW-1:0] v_total, v_sync_on, v_sync_off, v_blank_on, v_blank_off, v_drive_on, v_drive_off;
  logic comp_sync_n, comp_blank_n, line_drive_n, frame_drive_n, odd_field;

  always #5 clk = ~clk;

  stc_timing_core #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .en_load(en_load), .en_bit(en_bit), .freeze(freeze),
    .restart(restart), .clear(clear),
    .h_total(h_total), .h_sync_on(h_sync_on), .h_sync_off(h_sync_off),
    .h_blank_on(h_blank_on), .h_blank_off(h_blank_off),
    .h_drive_on(h_drive_on), .h_drive_off(h_drive_off),
    .v_total(v_total), .v_sync_on(v_sync_on), .v_sync_off(v_sync_off),
    .v_blank_on(v_blank_on), .v_blank_off(v_blank_off),
    .v_drive_on(v_drive_on), .v_drive_off(v_drive_off),
    .comp_sync_n(comp_sync_n), .comp_blank_n(comp_blank_n),
    .line_drive_n(line_drive_n), .frame_drive_n(frame_drive_n), .odd_field(odd_field)
  );

  int checks = 0;
  int fails = 0;
  string phase = "R1";

  // bench model state
  int  mh = 1, mv = 1;
  bit  mrun = 0;
  bit  m_hs, m_hb, m_hd, m_vs, m_vb, m_vd;

  function automatic bit inside_win(int c, int lo, int hi);
    return (c >= lo) && (c < hi);
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] %s: actual %b expected %b", req, phase, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int ht, vt;
    bit vs;
    ht = int'(h_total);
    vt = int'(v_total);
    if (clear || restart) begin
      mh = 1; mv = 1;
      {m_hs, m_hb, m_hd, m_vs, m_vb, m_vd} = '0;
    end else if (mrun && !freeze) begin
      m_hs = inside_win(mh, int'(h_sync_on),  int'(h_sync_off));
      m_hb = inside_win(mh, int'(h_blank_on), int'(h_blank_off));
      m_hd = inside_win(mh, int'(h_drive_on), int'(h_drive_off));
      m_vs = inside_win(mv, int'(v_sync_on),  int'(v_sync_off));
      m_vb = inside_win(mv, int'(v_blank_on), int'(v_blank_off));
      m_vd = inside_win(mv, int'(v_drive_on), int'(v_drive_off));
      vs = (mh == ht) || (mh == ht / 2);
      mh = (mh == ht) ? 1 : mh + 1;
      if (vs) mv = (mv == vt) ? 1 : mv + 1;
    end
    if (clear) mrun = 0;
    else if (en_load) mrun = en_bit;
  endtask

  task automatic compare_all();
    chk("R7", "comp_sync_n",  comp_sync_n,  ~(m_hs ^ m_vs));
    chk("R7", "comp_blank_n", comp_blank_n, ~(m_hb | m_vb));
    chk("R5", "line_drive_n", line_drive_n, ~m_hd);
    chk("R6", "frame_drive_n", frame_drive_n, ~m_vd);
    chk("R4", "odd_field",    odd_field,    (mv <= int'(v_total) / 2));
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic int pick(int lo, int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  // new programmed values, applied only while restart holds the block parked
  task automatic new_cfg();
    int ht, vt, a;
    ht = pick(16, 60);
    vt = 2 * pick(4, 13);
    h_total = CW'(ht); v_total = CW'(vt);
    a = pick(2, ht - 1); h_sync_on  = CW'(a); h_sync_off  = CW'(pick(a + 1, ht));
    a = pick(2, ht - 1); h_blank_on = CW'(a); h_blank_off = CW'(pick(a + 1, ht));
    a = pick(2, ht - 1); h_drive_on = CW'(a); h_drive_off = CW'(pick(a + 1, ht));
    a = pick(2, vt - 1); v_sync_on  = CW'(a); v_sync_off  = CW'(pick(a + 1, vt));
    a = pick(2, vt - 1); v_blank_on = CW'(a); v_blank_off = CW'(pick(a + 1, vt));
    a = pick(2, vt - 1); v_drive_on = CW'(a); v_drive_off = CW'(pick(a + 1, vt));
  endtask

  task automatic write_en(bit v);
    en_load = 1'b1; en_bit = v;
    tick();
    en_load = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog [%s]: actual hung expected finished", phase);
    summary();
  end

  initial begin
    void'($urandom(32'd20240612));
    h_total = 12'd40; v_total = 12'd22;
    h_sync_on = 12'd3;  h_sync_off = 12'd7;
    h_blank_on = 12'd30; h_blank_off = 12'd38;
    h_drive_on = 12'd2; h_drive_off = 12'd9;
    v_sync_on = 12'd3;  v_sync_off = 12'd6;
    v_blank_on = 12'd2; v_blank_off = 12'd8;
    v_drive_on = 12'd2; v_drive_off = 12'd5;

    // R1: reset state
    repeat (2) @(negedge clk);
    compare_all();
    chk("R1", "comp_sync_n at reset", comp_sync_n, 1'b1);
    chk("R1", "odd_field at reset", odd_field, 1'b1);
    rst_n = 1'b1;

    // R2: stays idle before enable is written
    phase = "R2 idle";
    ticks(60);
    chk("R2", "line_drive_n idle", line_drive_n, 1'b1);

    // R3 R4 R5 R6 R7: two full frames with the directed programming
    phase = "R3 R4 R5 R6 R7 run";
    write_en(1'b1);
    ticks(2 * 11 * 40 + 17);

    // R2: writing 0 stops generation mid-line
    phase = "R2 stop";
    write_en(1'b0);
    ticks(50);
    write_en(1'b1);
    ticks(30);

    // R8: freeze pulses of assorted lengths
    phase = "R8 freeze";
    for (int k = 0; k < 12; k++) begin
      freeze = 1'b1; ticks(pick(1, 9));
      freeze = 1'b0; ticks(pick(1, 25));
    end

    // R9: restart with new programming, then gen-lock
    phase = "R9 restart";
    for (int k = 0; k < 4; k++) begin
      restart = 1'b1; tick();
      new_cfg(); ticks(3);
      restart = 1'b0;
      ticks(pick(200, 900));
    end

    // R10: clear drops enable and stays stopped
    phase = "R10 clear";
    clear = 1'b1; ticks(2); clear = 1'b0;
    ticks(80);
    chk("R10", "comp_blank_n stopped", comp_blank_n, 1'b1);
    write_en(1'b1);
    ticks(300);

    // R11: collisions
    phase = "R11 restart+freeze";
    freeze = 1'b1; restart = 1'b1; ticks(2);
    restart = 1'b0; ticks(3); freeze = 1'b0; ticks(60);
    phase = "R11 clear+en_load";
    clear = 1'b1; en_load = 1'b1; en_bit = 1'b1; tick();
    clear = 1'b0; en_load = 1'b0;
    ticks(40);
    chk("R11", "frame_drive_n after clear", frame_drive_n, 1'b1);
    write_en(1'b1);
    ticks(100);

    // R11 random mix
    phase = "R11 random";
    for (int n = 0; n < 30000; n++) begin
      freeze  = ($urandom % 8) == 0;
      clear   = ($urandom % 400) == 0;
      en_load = ($urandom % 150) == 0;
      en_bit  = ($urandom % 4) != 0;
      restart = ($urandom % 300) == 0;
      if (restart) new_cfg();
      tick();
    end
    {freeze, clear, en_load, restart} = '0;
    ticks(5);
    summary();
  end
endmodule